// File: doc/BRIEF.md
# Row-Column Organized Static RAM

This block is a 1024-word by 4-bit static memory. The storage is a square array of 64 rows by 64 bits, not a tall column of 1024 short words. The upper six address bits pick one row. The lower four bits pick one 4-bit group inside that row.

Each row is made of four 16-bit slices, one slice per data bit. Data bit b of column c sits at row bit b*16+c. A read fetches the whole row and a column multiplexer picks the nibble. A write fetches the row, merges the new nibble into the selected column, and stores the row back.

The shared data pins are modelled as three signals: a write-data input, a read-data output and an output-valid flag. The flag stands for the pin leaving high impedance. Read data is registered, so it appears on the clock after the request.

Top module: `sram_rowcol`

## Requirements
- R1: Each of the 1024 addresses (addr[9:0]) holds its own 4-bit word. A read returns the value most recently written to that address.
- R2: When cs_n=0 and we_n=1 at a rising edge, the next cycle shows dout_oe=1 and dout equal to the word at addr.
- R3: When cs_n=0 and we_n=0 at a rising edge, din is stored at addr on that edge, and the next cycle shows dout_oe=0.
- R4: When cs_n=1 at a rising edge, nothing is stored, whatever the value of we_n. The next cycle shows dout_oe=0.
- R5: dout is 0 whenever dout_oe is 0, which is the modelled high-impedance state.
- R6: While rst_n is low, dout_oe is 0 and dout is 0. Reset does not clear the storage.
- R7: A write changes only the addressed word. The other 15 words in the same row (same addr[9:4]) keep their values.
- R8: A read on the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output register only |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| addr | input | 10 | Word address; [9:4] is the row, [3:0] is the column |
| din | input | 4 | Write data |
| dout | output | 4 | Registered read data |
| dout_oe | output | 1 | High while dout is driven (not high impedance) |

## Verification
If the column multiplexer or the merge logic selects the wrong slice position, the fault shows up in two ways. A read of a word that shares a row with a recent write returns bits of its neighbours one cycle after the read is issued. A later read of a neighbour returns a value changed by a write it was never the target of.

A faulty row decode or faulty select gating instead stores data in a row it should not touch. That fault stays hidden until the affected address is read. For this reason the bench fills every address before it reads any back.

An error in the enable decode shows directly at the port: dout_oe or a non-zero dout appears on the first cycle after the wrong request.

// File: rtl/sram_rowcol_pkg.sv
package sram_rowcol_pkg;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 4;
    localparam int COL_BITS = 4;
    localparam int ROW_BITS = ADDR_W - COL_BITS;
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int COLS     = 1 << COL_BITS;
    localparam int ROW_W    = DATA_W * COLS;

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } rd_port_t;
endpackage

// File: rtl/sram_col_mux.sv
module sram_col_mux #(
    parameter int DATA_W   = 4,
    parameter int COL_BITS = 4,
    localparam int COLS    = 1 << COL_BITS,
    localparam int ROW_W   = DATA_W * COLS
) (
    input  logic [ROW_W-1:0]    row,
    input  logic [COL_BITS-1:0] col,
    output logic [DATA_W-1:0]   word
);
    // one slice of COLS cells per data bit
    for (genvar b = 0; b < DATA_W; b++) begin : g_slice
        logic [COLS-1:0] slice;
        assign slice   = row[b*COLS +: COLS];
        assign word[b] = slice[col];
    end
endmodule

// File: rtl/sram_col_merge.sv
module sram_col_merge #(
    parameter int DATA_W   = 4,
    parameter int COL_BITS = 4,
    localparam int COLS    = 1 << COL_BITS,
    localparam int ROW_W   = DATA_W * COLS
) (
    input  logic [ROW_W-1:0]    row_in,
    input  logic [COL_BITS-1:0] col,
    input  logic [DATA_W-1:0]   wdata,
    output logic [ROW_W-1:0]    row_out
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_slice
        for (genvar c = 0; c < COLS; c++) begin : g_cell
            assign row_out[b*COLS+c] = (col == COL_BITS'(c)) ? wdata[b]
                                                              : row_in[b*COLS+c];
        end
    end
endmodule

// File: rtl/sram_rowcol.sv
module sram_rowcol
    import sram_rowcol_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    logic [ROW_W-1:0]    mem_q [ROWS];
    logic [ROW_BITS-1:0] row_sel;
    logic [COL_BITS-1:0] col_sel;
    logic [ROW_W-1:0]    row_rd;
    logic [ROW_W-1:0]    row_wr;
    logic [DATA_W-1:0]   word_rd;
    logic                rd_en;
    logic                wr_en;
    rd_port_t            port_d, port_q;

    assign row_sel = addr[ADDR_W-1 -: ROW_BITS];
    assign col_sel = addr[COL_BITS-1:0];
    assign rd_en   = !cs_n && we_n;
    assign wr_en   = !cs_n && !we_n;
    assign row_rd  = mem_q[row_sel];

    sram_col_mux #(.DATA_W(DATA_W), .COL_BITS(COL_BITS)) u_mux (
        .row  (row_rd),
        .col  (col_sel),
        .word (word_rd)
    );

    sram_col_merge #(.DATA_W(DATA_W), .COL_BITS(COL_BITS)) u_merge (
        .row_in  (row_rd),
        .col     (col_sel),
        .wdata   (din),
        .row_out (row_wr)
    );

    always_comb begin
        port_d = '0;
        if (rd_en) begin
            port_d.oe   = 1'b1;
            port_d.data = word_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    // storage array carries no reset
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[row_sel] <= row_wr;
    end

    assign dout    = port_q.data;
    assign dout_oe = port_q.oe;
endmodule

// File: rtl/sram_rowcol_chk.sv
module sram_rowcol_chk
    import sram_rowcol_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe
);
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n) |=> dout_oe); // R2
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> !dout_oe); // R3
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_oe); // R4
    AST_HIZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0)); // R5
    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) ##1 (!cs_n && we_n && addr == $past(addr))
        |=> (dout == $past(din, 2))); // R8
endmodule

bind sram_rowcol sram_rowcol_chk u_chk (.*);

// File: tb/sim_sram_rowcol.sv
module sim_sram_rowcol;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       we_n = 1'b1;
    logic [9:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_oe;

    typedef struct {
        logic       oe;
        logic [3:0] data;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [3:0] ref_mem [1024];
    int         n_checks = 0;
    int         n_errors = 0;
    bit         finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_rowcol u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input string tag, input logic oe_a, input logic [3:0] d_a,
                         input logic oe_e, input logic [3:0] d_e);
        n_checks++;
        if (oe_a !== oe_e || d_a !== d_e) begin
            n_errors++;
            $display("FAIL %s: got oe=%0b dout=%h, expected oe=%0b dout=%h",
                     tag, oe_a, d_a, oe_e, d_e);
        end
    endtask

    function automatic logic [3:0] pat(input int a, input int salt);
        return 4'((a & 15) ^ ((a >> 4) & 15) ^ ((a >> 8) * 5) ^ salt);
    endfunction

    // driver: applies one request per cycle and queues its expected result
    task automatic op(input logic c, input logic w, input int a, input logic [3:0] d,
                      input string tag);
        exp_t e;
        @(negedge clk);
        cs_n = c; we_n = w; addr = 10'(a); din = d;
        e.tag = tag;
        if (!c && w) begin e.oe = 1'b1; e.data = ref_mem[a]; end
        else begin e.oe = 1'b0; e.data = 4'h0; end
        if (!c && !w) ref_mem[a] = d;
        sb_q.push_back(e);
    endtask

    // monitor: compares after each edge
    always begin
        @(posedge clk);
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, dout_oe, dout, e.oe, e.data);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R6: outputs quiet during reset
        repeat (3) @(negedge clk);
        check("R6 reset", dout_oe, dout, 1'b0, 4'h0);
        rst_n = 1'b1;

        // R1 / R3: fill all addresses
        for (int a = 0; a < 1024; a++) op(1'b0, 1'b0, a, pat(a, 0), "R3 write quiet");
        // R1 / R2: read every address back
        for (int a = 0; a < 1024; a++) op(1'b0, 1'b1, a, 4'h0, "R1 R2 readback");

        // R7: one write in row 5, then all 16 neighbours
        op(1'b0, 1'b0, (5 << 4) | 9, ~pat((5 << 4) | 9, 0), "R7 write");
        for (int c = 0; c < 16; c++) op(1'b0, 1'b1, (5 << 4) | c, 4'h0, "R7 row neighbours");

        // R7: write the top column of the last row, read its row
        op(1'b0, 1'b0, 1023, 4'hA, "R7 write");
        for (int c = 0; c < 16; c++) op(1'b0, 1'b1, (63 << 4) | c, 4'h0, "R7 last row");

        // R4: deselected write stores nothing; deselected read stays quiet
        op(1'b1, 1'b0, 100, ~pat(100, 0), "R4 deselect we");
        op(1'b1, 1'b1, 100, 4'h0, "R4 R5 deselect rd");
        op(1'b0, 1'b1, 100, 4'h0, "R4 unchanged");

        // R8: back-to-back write then read at several addresses
        for (int k = 0; k < 8; k++) begin
            op(1'b0, 1'b0, k * 131, pat(k, 7), "R8 write");
            op(1'b0, 1'b1, k * 131, 4'h0, "R8 read after write");
        end

        // R5: idle after traffic
        op(1'b1, 1'b1, 0, 4'hF, "R5 idle");

        // R6: reset does not clear storage
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 reset again", dout_oe, dout, 1'b0, 4'h0);
        rst_n = 1'b1;
        op(1'b0, 1'b1, 262, 4'h0, "R6 storage kept");
        op(1'b0, 1'b1, 777, 4'h0, "R1 R6 storage kept");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule